// File: doc/BRIEF.md
# Load-Use Hazard Detection Unit

This block sits in the decode stage of a five-stage in-order pipeline. Each cycle it compares the source registers of the decoding instruction with the destination of the instruction one stage ahead. When that instruction is a load whose result the decoder needs, the block holds the front of the pipeline for one cycle. During that cycle the program counter and the fetch/decode pipeline register keep their contents, and the control fields entering the execute stage are forced to zero, so a no-op moves forward in place of the dependent instruction. The load moves on normally, and on the next cycle its result can be forwarded.

The block also handles a structural conflict. When the design is set up for one memory shared by instruction fetch and data access, fetch must wait whenever a load or a store holds the memory stage. This uses the same stall mechanism. When both causes occur together, the result is one combined stall rather than two separate ones.

The block is purely combinational, and the pipeline registers it controls live outside it. Parameters set the register index width, the number of decoded source operands, whether register 0 is hard-wired, and whether the shared-memory check is built at all.

Top module: `load_use_hazard_unit`

## Requirements
- R1: With `ex_mem_read` high and a nonzero `ex_dst` equal to source 0 (`dec_srcs[4:0]`, the rs field) while `dec_src_used[0]` is high, the block stalls.
- R2: With `ex_mem_read` high and a nonzero `ex_dst` equal to source 1 (`dec_srcs[9:5]`, the rt field) while `dec_src_used[1]` is high, the block stalls.
- R3: A source whose `dec_src_used` bit is low never causes a stall, even when its field equals `ex_dst`.
- R4: A load whose destination `ex_dst` is 0 never causes a load-use stall.
- R5: With `ex_mem_read` low, no register match causes a stall.
- R6: In a stall cycle `pc_we` and `ifid_we` are 0 and `idex_bubble` is 1. In every other cycle `pc_we` and `ifid_we` are 1 and `idex_bubble` is 0.
- R7: With `unified_mem` high, a high `mem_ls_active` (a load or a store in the memory stage) causes a stall.
- R8: With `unified_mem` low, `mem_ls_active` has no effect on the outputs.
- R9: When a load-use match and a structural conflict occur together, the outputs are identical to those of a single stall. After the bubble has replaced the dependent slot (`ex_mem_read` low on the next cycle, with no memory conflict), the stall is released, so a load-use stall lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_srcs | input | NUM_SRC*REG_W | Source register fields of the decoding instruction, source 0 in the lowest bits |
| dec_src_used | input | NUM_SRC | One bit per source; high when the instruction reads that source |
| ex_mem_read | input | 1 | Memory-read flag of the instruction in the execute-stage register |
| ex_dst | input | REG_W | Load destination (rt) field of the execute-stage register |
| mem_ls_active | input | 1 | A load or a store occupies the memory stage |
| unified_mem | input | 1 | Configuration: instruction and data share one memory |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| idex_bubble | output | 1 | Forces every control field written into the execute-stage register to zero |

## Verification
On every evaluation the assertions check three things: the two enables and the bubble signal always agree with one another; a hit on any used source with a nonzero load destination produces a stall; and an idle or unused input never produces one. The one-cycle length of a load-use stall depends on the execute-stage register outside the block. Only the bench scenarios can show it, by feeding the bubble back as the next cycle's execute-stage contents. The interaction of both stall causes, and the dependence of the structural stall on the configuration bit, are also shown through directed and random vectors compared against the bench's own model.

// File: rtl/luh_pkg.sv
package luh_pkg;

   typedef struct packed {
      logic pc_we;
      logic ifid_we;
      logic bubble;
   } luh_ctrl_t;

   function automatic luh_ctrl_t luh_ctrl_from_stall(input logic stall);
      luh_ctrl_t c;
      c.pc_we   = ~stall;
      c.ifid_we = ~stall;
      c.bubble  = stall;
      return c;
   endfunction

endpackage

// File: rtl/luh_src_match.sv
module luh_src_match #(
   parameter int REG_W       = 5,
   parameter bit ZERO_FIXED  = 1'b1
) (
   input  logic [REG_W-1:0] src_idx,
   input  logic             src_used,
   input  logic             ld_valid,
   input  logic [REG_W-1:0] ld_dst,
   output logic             hit
);

   logic dst_live;

   generate
      if (ZERO_FIXED) begin : g_zero_fixed
         assign dst_live = |ld_dst;
      end else begin : g_zero_plain
         assign dst_live = 1'b1;
      end
   endgenerate

   assign hit = ld_valid & src_used & dst_live & (src_idx == ld_dst);

endmodule

// File: rtl/luh_struct_guard.sv
module luh_struct_guard #(
   parameter bit SHARED_MEM_EN = 1'b1
) (
   input  logic unified_cfg,
   input  logic mem_busy,
   output logic hit
);

   generate
      if (SHARED_MEM_EN) begin : g_shared
         assign hit = unified_cfg & mem_busy;
      end else begin : g_split
         assign hit = unified_cfg & mem_busy & 1'b0;
      end
   endgenerate

endmodule

// File: rtl/luh_stall_ctrl.sv
module luh_stall_ctrl
   import luh_pkg::*;
#(
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] src_hits,
   input  logic               struct_hit,
   output luh_ctrl_t          ctrl
);

   logic stall;

   assign stall = (|src_hits) | struct_hit;
   assign ctrl  = luh_ctrl_from_stall(stall);

endmodule

// File: rtl/load_use_hazard_unit.sv
module load_use_hazard_unit
   import luh_pkg::*;
#(
   parameter int REG_W         = 5,
   parameter int NUM_SRC       = 2,
   parameter bit ZERO_FIXED    = 1'b1,
   parameter bit SHARED_MEM_EN = 1'b1
) (
   input  logic [NUM_SRC*REG_W-1:0] dec_srcs,
   input  logic [NUM_SRC-1:0]       dec_src_used,
   input  logic                     ex_mem_read,
   input  logic [REG_W-1:0]         ex_dst,
   input  logic                     mem_ls_active,
   input  logic                     unified_mem,
   output logic                     pc_we,
   output logic                     ifid_we,
   output logic                     idex_bubble
);

   localparam int SRC_BUS_W = NUM_SRC * REG_W;

   generate
      if (REG_W < 1) begin : g_bad_width
         $error("load_use_hazard_unit: REG_W must be at least 1");
      end
      if (NUM_SRC < 1) begin : g_bad_count
         $error("load_use_hazard_unit: NUM_SRC must be at least 1");
      end
      if (SRC_BUS_W != $bits(dec_srcs)) begin : g_bad_bus
         $error("load_use_hazard_unit: source bus width mismatch");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_hits;
   logic               struct_hit;
   luh_ctrl_t          ctrl;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         luh_src_match #(
            .REG_W      (REG_W),
            .ZERO_FIXED (ZERO_FIXED)
         ) u_match (
            .src_idx  (dec_srcs[g*REG_W +: REG_W]),
            .src_used (dec_src_used[g]),
            .ld_valid (ex_mem_read),
            .ld_dst   (ex_dst),
            .hit      (src_hits[g])
         );
      end
   endgenerate

   luh_struct_guard #(
      .SHARED_MEM_EN (SHARED_MEM_EN)
   ) u_struct (
      .unified_cfg (unified_mem),
      .mem_busy    (mem_ls_active),
      .hit         (struct_hit)
   );

   luh_stall_ctrl #(
      .NUM_SRC (NUM_SRC)
   ) u_ctrl (
      .src_hits   (src_hits),
      .struct_hit (struct_hit),
      .ctrl       (ctrl)
   );

   assign pc_we       = ctrl.pc_we;
   assign ifid_we     = ctrl.ifid_we;
   assign idex_bubble = ctrl.bubble;

endmodule

// File: rtl/load_use_hazard_unit_chk.sv
module load_use_hazard_unit_chk #(
   parameter int REG_W   = 5,
   parameter int NUM_SRC = 2
) (
   input logic [NUM_SRC*REG_W-1:0] dec_srcs,
   input logic [NUM_SRC-1:0]       dec_src_used,
   input logic                     ex_mem_read,
   input logic [REG_W-1:0]         ex_dst,
   input logic                     mem_ls_active,
   input logic                     unified_mem,
   input logic                     pc_we,
   input logic                     ifid_we,
   input logic                     idex_bubble,
   input logic [NUM_SRC-1:0]       src_hits,
   input logic                     struct_hit
);

   logic known;
   logic any_use_hit;

   always_comb begin
      any_use_hit = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (dec_src_used[i] && (dec_srcs[i*REG_W +: REG_W] == ex_dst))
            any_use_hit = 1'b1;
      end
   end

   assign known = !$isunknown({dec_srcs, dec_src_used, ex_mem_read, ex_dst,
                               mem_ls_active, unified_mem});

   always_comb begin
      if (known) begin
         // R6: the three outputs always move together
         p_outputs_agree_r6: assert ((pc_we == ifid_we) && (idex_bubble == !pc_we));
         // R1, R2: a used-source hit on a live load destination stalls
         p_use_hit_stalls_r1: assert (!(ex_mem_read && (ex_dst != '0) && any_use_hit) || idex_bubble);
         // R5: no load and no memory conflict means no stall
         p_idle_no_stall_r5: assert (ex_mem_read || (unified_mem && mem_ls_active) || pc_we);
         // R4: zero destination is never a load-use hazard
         p_zero_dst_r4: assert (!((ex_dst == '0) && !(unified_mem && mem_ls_active)) || pc_we);
         // R8: split memory ignores memory-stage traffic
         p_split_mem_r8: assert (!(!unified_mem && !ex_mem_read) || !idex_bubble);
         // R7: shared memory with traffic in the memory stage stalls
         p_shared_stall_r7: assert (!(unified_mem && mem_ls_active) || (struct_hit && !pc_we));
         // R3: a stall from operand matching implies some used source matched
         p_unused_src_r3: assert (!(|src_hits) || any_use_hit);
      end
   end

endmodule

bind load_use_hazard_unit load_use_hazard_unit_chk #(
   .REG_W   (REG_W),
   .NUM_SRC (NUM_SRC)
) u_chk (
   .dec_srcs      (dec_srcs),
   .dec_src_used  (dec_src_used),
   .ex_mem_read   (ex_mem_read),
   .ex_dst        (ex_dst),
   .mem_ls_active (mem_ls_active),
   .unified_mem   (unified_mem),
   .pc_we         (pc_we),
   .ifid_we       (ifid_we),
   .idex_bubble   (idex_bubble),
   .src_hits      (src_hits),
   .struct_hit    (struct_hit)
);

// File: tb/load_use_hazard_unit_bench.sv
`timescale 1ns/1ps
module load_use_hazard_unit_bench;

   localparam int RW = 5;
   localparam int NS = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [NS*RW-1:0] dec_srcs;
   logic [NS-1:0]    dec_src_used;
   logic             ex_mem_read;
   logic [RW-1:0]    ex_dst;
   logic             mem_ls_active;
   logic             unified_mem;
   logic             pc_we, ifid_we, idex_bubble;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   load_use_hazard_unit #(.REG_W(RW), .NUM_SRC(NS)) u_load_use_hazard_unit (
      .dec_srcs      (dec_srcs),
      .dec_src_used  (dec_src_used),
      .ex_mem_read   (ex_mem_read),
      .ex_dst        (ex_dst),
      .mem_ls_active (mem_ls_active),
      .unified_mem   (unified_mem),
      .pc_we         (pc_we),
      .ifid_we       (ifid_we),
      .idex_bubble   (idex_bubble)
   );

   // Behavioural reference: integer arithmetic, independent of the RTL
   function automatic bit model_stall(int rs, int rt, bit use_rs, bit use_rt,
                                      bit ld, int dst, bit ls, bit uni);
      bit s = 0;
      if (ld && dst != 0 && use_rs && rs == dst) s = 1;
      if (ld && dst != 0 && use_rt && rt == dst) s = 1;
      if (uni && ls) s = 1;
      return s;
   endfunction

   task automatic apply(input string req, input int rs, input int rt,
                        input bit use_rs, input bit use_rt, input bit ld,
                        input int dst, input bit ls, input bit uni);
      bit exp_s;
      @(negedge clk);
      dec_srcs      = {rt[RW-1:0], rs[RW-1:0]};
      dec_src_used  = {use_rt, use_rs};
      ex_mem_read   = ld;
      ex_dst        = dst[RW-1:0];
      mem_ls_active = ls;
      unified_mem   = uni;
      #1;
      exp_s = model_stall(rs, rt, use_rs, use_rt, ld, dst, ls, uni);
      vectors++;
      if ({pc_we, ifid_we, idex_bubble} != {!exp_s, !exp_s, exp_s}) begin
         errors++;
         $display("FAIL %s: got pc_we=%0b ifid_we=%0b bubble=%0b expected %0b %0b %0b",
                  req, pc_we, ifid_we, idex_bubble, !exp_s, !exp_s, exp_s);
      end
   endtask

   initial begin : watchdog
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      // reset-like idle state: nothing in flight
      apply("R6 idle", 0, 0, 0, 0, 0, 0, 0, 0);
      apply("R1 rs match", 3, 7, 1, 1, 1, 3, 0, 0);
      apply("R2 rt match", 4, 9, 1, 1, 1, 9, 0, 0);
      apply("R3 rt unused", 4, 9, 1, 0, 1, 9, 0, 0);
      apply("R3 rs unused", 9, 4, 0, 1, 1, 9, 0, 0);
      apply("R4 dst zero", 0, 0, 1, 1, 1, 0, 0, 0);
      apply("R5 no load", 6, 6, 1, 1, 0, 6, 0, 0);
      apply("R6 no match", 1, 2, 1, 1, 1, 31, 0, 0);
      apply("R7 shared busy", 1, 2, 1, 1, 0, 5, 1, 1);
      apply("R7 shared idle", 1, 2, 1, 1, 0, 5, 0, 1);
      apply("R8 split busy", 1, 2, 1, 1, 0, 5, 1, 0);
      apply("R8 split busy load", 1, 2, 1, 1, 1, 2, 1, 0);
      apply("R9 combined", 8, 8, 1, 1, 1, 8, 1, 1);
      // R9: stall cycle, then bubble occupies execute stage -> release
      apply("R9 stall", 12, 3, 1, 1, 1, 12, 0, 0);
      apply("R9 release", 12, 3, 1, 1, 0, 0, 0, 0);
      apply("R1 max index", 31, 0, 1, 0, 1, 31, 0, 0);
      for (int i = 0; i < 2000; i++) begin
         apply("R1 R2 R7 random", $urandom_range(0, 31), $urandom_range(0, 31),
               1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 7),
               1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule